// File: doc/BRIEF.md
# Ping-Pong Swap Register File

This block is a double-buffered register file placed between an execution pipeline and an I/O agent. It holds two physical banks of equal size. At any moment the execution side (side A) works on one bank and the I/O side (side B) works on the other. The execution core can compute in its bank while the I/O agent fills in fresh operands or drains finished results from the other bank.

A one-bit select register decides which bank each side owns. A flip request pulse inverts the select, and this exchanges the two banks between the sides. Operands loaded by the I/O side then appear at the execution side, and results written by the execution side appear at the I/O side. No data is copied.

Each side has one synchronous write port and two combinational read ports with independent addresses. The two sides always address different banks, so they never collide and need no arbitration. Each bank holds 2^ADDR_W words of DATA_W bits. By default that is 32 words on a 5-bit offset.

Top module: `pingpong_regfile`

## Requirements
- R1: Reset clears the select to 0. With select 0, side A accesses bank 0 and side B accesses bank 1. With select 1, the mapping is reversed.
- R2: The select inverts on a rising clock edge where `flip_i` is 1. It holds its value on every edge where `flip_i` is 0.
- R3: A write from either side (write enable 1) is stored at the rising edge into the bank that side currently owns. A later read by that side at the same address, with no flip in between, returns the written data.
- R4: Reads are combinational from the array. A read of an address that is being written in the same cycle returns the value stored before that edge.
- R5: Side A and side B may both write in the same cycle, including to the same offset. Both words are kept, each in its own side's bank.
- R6: After a flip, each side reads the contents that the other side saw before the flip, at every offset.
- R7: A write issued in the same cycle as a flip request lands in the bank that side owned before the flip. After the flip it is therefore readable by the other side.
- R8: Reset changes only the select. Bank contents written before reset are readable unchanged afterwards.
- R9: The two read ports of a side take independent addresses in the same cycle, and each returns its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the select register |
| flip_i | input | 1 | Bank exchange request; inverts the select at the edge |
| a_we_i | input | 1 | Side A write enable |
| a_waddr_i | input | ADDR_W | Side A write offset |
| a_wdata_i | input | DATA_W | Side A write data |
| a_raddr0_i | input | ADDR_W | Side A read port 0 offset |
| a_raddr1_i | input | ADDR_W | Side A read port 1 offset |
| a_rdata0_o | output | DATA_W | Side A read port 0 data |
| a_rdata1_o | output | DATA_W | Side A read port 1 data |
| b_we_i | input | 1 | Side B write enable |
| b_waddr_i | input | ADDR_W | Side B write offset |
| b_wdata_i | input | DATA_W | Side B write data |
| b_raddr0_i | input | ADDR_W | Side B read port 0 offset |
| b_raddr1_i | input | ADDR_W | Side B read port 1 offset |
| b_rdata0_o | output | DATA_W | Side B read port 0 data |
| b_rdata1_o | output | DATA_W | Side B read port 1 data |

## Verification
Both banks are filled at every offset in one sweep, with side A and side B writing the same offset in each cycle. The two data patterns are chosen so that a steering error shows up as a pattern belonging to the wrong side. Full read sweeps use mirrored and rotated address pairs on the two ports of each side. These sweeps are repeated after a flip, after a double flip and after a reset taken while the select is 1. Together they tell a correct bank exchange apart from a stuck select, a port crossover and reset corrupting the data. Directed cases cover a read of the word being written in the same cycle and a write issued in a flip cycle. A long pseudo-random phase then mixes writes, flips and reads on all ports against an arithmetic model of the two banks.

// File: rtl/pp_regfile_pkg.sv
package pp_regfile_pkg;
   localparam int unsigned NBANK = 2;
   localparam int unsigned NRD   = 2;

   typedef enum logic {SIDE_EXEC = 1'b0, SIDE_IO = 1'b1} side_e;

   // Which side owns a bank for a given select value.
   function automatic side_e bank_owner(input logic sel, input logic bank);
      return (sel == bank) ? SIDE_EXEC : SIDE_IO;
   endfunction
endpackage

// File: rtl/pp_select.sv
module pp_select (
   input  logic clk,
   input  logic rst_n,
   input  logic flip_i,
   output logic sel_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_o <= 1'b0;
      else if (flip_i)
         sel_o <= ~sel_o;
   end
endmodule

// File: rtl/pp_bank.sv
module pp_bank #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned NRD    = 2
) (
   input  logic                       clk,
   input  logic                       we_i,
   input  logic [ADDR_W-1:0]          waddr_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [NRD-1:0][ADDR_W-1:0] raddr_i,
   output logic [NRD-1:0][DATA_W-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i)
         mem_q[waddr_i] <= wdata_i;
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rdata_o[r] = mem_q[raddr_i[r]];
   end
endmodule

// File: rtl/pingpong_regfile.sv
module pingpong_regfile
   import pp_regfile_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flip_i,
   input  logic              a_we_i,
   input  logic [ADDR_W-1:0] a_waddr_i,
   input  logic [DATA_W-1:0] a_wdata_i,
   input  logic [ADDR_W-1:0] a_raddr0_i,
   input  logic [ADDR_W-1:0] a_raddr1_i,
   output logic [DATA_W-1:0] a_rdata0_o,
   output logic [DATA_W-1:0] a_rdata1_o,
   input  logic              b_we_i,
   input  logic [ADDR_W-1:0] b_waddr_i,
   input  logic [DATA_W-1:0] b_wdata_i,
   input  logic [ADDR_W-1:0] b_raddr0_i,
   input  logic [ADDR_W-1:0] b_raddr1_i,
   output logic [DATA_W-1:0] b_rdata0_o,
   output logic [DATA_W-1:0] b_rdata1_o
);
   if (DATA_W < 1) begin : g_bad_data_w
      $error("pingpong_regfile: DATA_W must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("pingpong_regfile: ADDR_W must lie in 1..10");
   end

   logic sel_q;

   pp_select u_select (
      .clk    (clk),
      .rst_n  (rst_n),
      .flip_i (flip_i),
      .sel_o  (sel_q)
   );

   // side-facing read address bundles
   logic [NRD-1:0][ADDR_W-1:0] a_raddr, b_raddr;
   assign a_raddr = {a_raddr1_i, a_raddr0_i};
   assign b_raddr = {b_raddr1_i, b_raddr0_i};

   logic [NRD-1:0][DATA_W-1:0] bank_rdata [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic                       bk_we;
      logic [ADDR_W-1:0]          bk_waddr;
      logic [DATA_W-1:0]          bk_wdata;
      logic [NRD-1:0][ADDR_W-1:0] bk_raddr;

      always_comb begin
         if (bank_owner(sel_q, 1'(b)) == SIDE_EXEC) begin
            bk_we    = a_we_i;
            bk_waddr = a_waddr_i;
            bk_wdata = a_wdata_i;
            bk_raddr = a_raddr;
         end else begin
            bk_we    = b_we_i;
            bk_waddr = b_waddr_i;
            bk_wdata = b_wdata_i;
            bk_raddr = b_raddr;
         end
      end

      pp_bank #(
         .DATA_W (DATA_W),
         .ADDR_W (ADDR_W),
         .NRD    (NRD)
      ) u_bank (
         .clk     (clk),
         .we_i    (bk_we),
         .waddr_i (bk_waddr),
         .wdata_i (bk_wdata),
         .raddr_i (bk_raddr),
         .rdata_o (bank_rdata[b])
      );
   end

   // read crossbar: side A sees bank[sel], side B sees bank[~sel]
   logic [NRD-1:0][DATA_W-1:0] a_rd, b_rd;
   assign a_rd = sel_q ? bank_rdata[1] : bank_rdata[0];
   assign b_rd = sel_q ? bank_rdata[0] : bank_rdata[1];

   assign a_rdata0_o = a_rd[0];
   assign a_rdata1_o = a_rd[1];
   assign b_rdata0_o = b_rd[0];
   assign b_rdata1_o = b_rd[1];
endmodule

// File: rtl/pingpong_regfile_chk.sv
module pingpong_regfile_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flip,
   input logic              sel,
   input logic              a_we,
   input logic [ADDR_W-1:0] a_waddr,
   input logic [DATA_W-1:0] a_wdata,
   input logic [ADDR_W-1:0] a_raddr0,
   input logic [DATA_W-1:0] a_rdata0,
   input logic              b_we,
   input logic [ADDR_W-1:0] b_waddr,
   input logic [DATA_W-1:0] b_wdata,
   input logic [ADDR_W-1:0] b_raddr0,
   input logic [DATA_W-1:0] b_rdata0
);
   AST_SEL_AFTER_RESET: assert property (@(posedge clk) $rose(rst_n) |-> sel == 1'b0); // R1

   AST_SEL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      flip |=> sel != $past(sel)); // R2

   AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !flip |=> $stable(sel)); // R2

   AST_A_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      a_we && !flip |=> (a_raddr0 != $past(a_waddr)) || (a_rdata0 == $past(a_wdata))); // R3

   AST_B_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      b_we && !flip |=> (b_raddr0 != $past(b_waddr)) || (b_rdata0 == $past(b_wdata))); // R3

   AST_A_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      a_we && flip |=> (b_raddr0 != $past(a_waddr)) || (b_rdata0 == $past(a_wdata))); // R7

   AST_B_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      b_we && flip |=> (a_raddr0 != $past(b_waddr)) || (a_rdata0 == $past(b_wdata))); // R7
endmodule

bind pingpong_regfile pingpong_regfile_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flip     (flip_i),
   .sel      (sel_q),
   .a_we     (a_we_i),
   .a_waddr  (a_waddr_i),
   .a_wdata  (a_wdata_i),
   .a_raddr0 (a_raddr0_i),
   .a_rdata0 (a_rdata0_o),
   .b_we     (b_we_i),
   .b_waddr  (b_waddr_i),
   .b_wdata  (b_wdata_i),
   .b_raddr0 (b_raddr0_i),
   .b_rdata0 (b_rdata0_o)
);

// File: tb/pingpong_regfile_tb_top.sv
module pingpong_regfile_tb_top;
   localparam int DW    = 16;
   localparam int AW    = 5;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flip = 1'b0;
   logic a_we = 1'b0, b_we = 1'b0;
   logic [AW-1:0] a_wa = '0, a_r0 = '0, a_r1 = '0;
   logic [AW-1:0] b_wa = '0, b_r0 = '0, b_r1 = '0;
   logic [DW-1:0] a_wd = '0, b_wd = '0;
   logic [DW-1:0] a_d0, a_d1, b_d0, b_d1;

   always #5 clk = ~clk;

   pingpong_regfile #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .flip_i(flip),
      .a_we_i(a_we), .a_waddr_i(a_wa), .a_wdata_i(a_wd),
      .a_raddr0_i(a_r0), .a_raddr1_i(a_r1), .a_rdata0_o(a_d0), .a_rdata1_o(a_d1),
      .b_we_i(b_we), .b_waddr_i(b_wa), .b_wdata_i(b_wd),
      .b_raddr0_i(b_r0), .b_raddr1_i(b_r1), .b_rdata0_o(b_d0), .b_rdata1_o(b_d1)
   );

   // reference model: two banks and the expected select
   logic [DW-1:0] mdl [2][DEPTH];
   logic msel = 1'b0;
   int vectors = 0;
   int miscompares = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #2_000_000;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      miscompares++;
      report();
   end

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: commit writes and flip into the model, return at negedge
   task automatic cyc();
      @(posedge clk);
      if (rst_n) begin
         if (a_we) mdl[msel][a_wa] = a_wd;
         if (b_we) mdl[~msel][b_wa] = b_wd;
         if (flip) msel = ~msel;
      end
      @(negedge clk);
   endtask

   task automatic check_reads(input string req);
      #1;
      chk({req, " A port0"}, a_d0, mdl[msel][a_r0]);
      chk({req, " A port1"}, a_d1, mdl[msel][a_r1]);
      chk({req, " B port0"}, b_d0, mdl[~msel][b_r0]);
      chk({req, " B port1"}, b_d1, mdl[~msel][b_r1]);
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < DEPTH; a++) begin
         a_r0 = AW'(a); a_r1 = AW'(DEPTH-1-a);
         b_r0 = AW'(a); b_r1 = AW'(a + 7);
         check_reads(req);
      end
   endtask

   task automatic idle();
      a_we = 1'b0; b_we = 1'b0; flip = 1'b0;
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      @(negedge clk);
      cyc(); cyc();
      rst_n = 1'b1;
      @(negedge clk);

      // R5: fill both banks, both sides writing the same offset each cycle
      for (int a = 0; a < DEPTH; a++) begin
         a_we = 1'b1; a_wa = AW'(a); a_wd = DW'(16'h1000 + a * 3);
         b_we = 1'b1; b_wa = AW'(a); b_wd = DW'(16'hB000 + a * 5);
         cyc();
      end
      idle();
      // R1: after reset, side A holds the A pattern and side B holds the B pattern
      a_r0 = 5'd9; b_r0 = 5'd9; #1;
      chk("R1 side A owns bank 0 after reset", a_d0, DW'(16'h1000 + 9 * 3));
      chk("R1 side B owns bank 1 after reset", b_d0, DW'(16'hB000 + 9 * 5));
      sweep("R5 R9 fill readback");

      // R4: read of a word being written this cycle returns the old value
      a_we = 1'b1; a_wa = 5'd5; a_wd = 16'h5A5A; a_r0 = 5'd5; a_r1 = 5'd6; #1;
      chk("R4 same-cycle read old value", a_d0, DW'(16'h1000 + 5 * 3));
      cyc(); idle(); #1;
      chk("R3 write readback", a_d0, 16'h5A5A);
      b_we = 1'b1; b_wa = 5'd31; b_wd = 16'hC3C3; b_r0 = 5'd31; #1;
      chk("R4 same-cycle read old value side B", b_d0, DW'(16'hB000 + 31 * 5));
      cyc(); idle(); #1;
      chk("R3 write readback side B", b_d0, 16'hC3C3);

      // R2 R6: flip, then the sides exchange their views
      flip = 1'b1; cyc(); idle();
      a_r0 = 5'd9; b_r0 = 5'd9; #1;
      chk("R6 A sees former B data", a_d0, DW'(16'hB000 + 9 * 5));
      chk("R6 B sees former A data", b_d0, DW'(16'h1000 + 9 * 3));
      sweep("R6 after flip");
      // R2: no flip request, mapping holds
      cyc(); cyc(); cyc();
      sweep("R2 hold without flip");

      // R7: writes in the flip cycle land in the pre-flip banks
      a_we = 1'b1; a_wa = 5'd12; a_wd = 16'h7E57;
      b_we = 1'b1; b_wa = 5'd12; b_wd = 16'h0FF1;
      flip = 1'b1; cyc(); idle();
      a_r0 = 5'd12; b_r0 = 5'd12; #1;
      chk("R7 A flip-cycle write seen by B", b_d0, 16'h7E57);
      chk("R7 B flip-cycle write seen by A", a_d0, 16'h0FF1);

      // R2: two flips in a row return to the same mapping
      flip = 1'b1; cyc(); cyc(); idle();
      sweep("R2 double flip");
      flip = 1'b1; cyc(); idle();   // select now 1

      // R1 R8: reset with select 1 clears only the select
      rst_n = 1'b0; cyc(); cyc(); msel = 1'b0;
      rst_n = 1'b1; @(negedge clk);
      a_r0 = 5'd12; b_r0 = 5'd12; #1;
      chk("R1 select cleared by reset", a_d0, 16'h0FF1);
      chk("R8 bank contents kept over reset", b_d0, 16'h7E57);
      sweep("R8 contents after reset");

      // R3 R6 R7 R9: pseudo-random mix on all ports
      for (int i = 0; i < 600; i++) begin
         step_lfsr();
         a_we = lfsr[0]; b_we = lfsr[1]; flip = (lfsr[4:2] == 3'd0);
         a_wa = lfsr[9:5]; b_wa = lfsr[14:10];
         step_lfsr(); a_wd = lfsr;
         step_lfsr(); b_wd = lfsr;
         step_lfsr(); a_r0 = lfsr[4:0]; a_r1 = lfsr[9:5]; b_r0 = lfsr[14:10];
         step_lfsr(); b_r1 = lfsr[4:0];
         if (lfsr[7]) a_r0 = a_wa;
         if (lfsr[8]) b_r0 = a_wa;
         check_reads("R3 R9 random mix");
         cyc();
      end
      idle();
      sweep("R6 R7 final state");
      report();
   end
endmodule